// File: doc/BRIEF.md
# Pipelined Nine-Tap Carry-Save FIR Filter

This block is a programmable finite impulse response filter for one real rail of an adaptive equalizer. Each clock it takes one signed sample and returns one filtered word. All taps see the same sample at once. Each tap forms its own product, and the tap chain carries the running total as two separate words, a sum word and a carry word, held in per-tap registers. Because no carry ever ripples inside the chain, the longest path through a tap is one multiply plus one full-adder level. That path does not grow with the number of taps or with the word lengths. A single carry-propagate adder at the end of the chain merges the two words, and the top bits of the result are registered as the output.

The adaptation logic writes the coefficients through a parallel port. A one-cycle strobe copies the whole set into the tap registers on a single edge. A small sequencer tracks whether the output word reflects only real samples and only the current coefficient set. It has three states:
- `ST_PRIME`: the pipeline is filling after reset.
- `ST_RUN`: the output is trustworthy.
- `ST_SETTLE`: a new set is still working its way through the chain.

The sequencer makes these transitions:
- `PRIME_DONE` takes `ST_PRIME` to `ST_RUN` once the fill count expires.
- `LOAD_SEEN` takes any state to `ST_SETTLE` on a strobe and restarts the count.
- `SETTLE_DONE` takes `ST_SETTLE` to `ST_RUN` once the settle count expires.
- `HOLD` keeps the current state in all other cases.

Top module: `cs_fir9`

## Requirements
- R1: While reset is low, and after it, `y_out` is 0, `out_valid` is 0 and every coefficient is 0. With no load since reset, the output stays 0 whatever samples arrive.
- R2: Number the rising edges after reset release 1, 2, .... `x[e]` is the sample captured at edge e, and `x[e]` = 0 for e ≤ 0. After edge m, `y_out` equals floor(Σk ck·x[m-2-k] / 1024) for k = 0..8. This gives three register stages from input to output.
- R3: Tap k takes its coefficient from `coef_in[k*10 +: 10]`. Tap 0 weights the newest sample and tap 8 the oldest.
- R4: When `coef_load` is 1 at an edge, all nine coefficients are captured on that edge together. Changes on `coef_in` while `coef_load` is 0 have no effect on `y_out`.
- R5: A set captured at edge L is first used by every tap at edge L+1. Tap k of the output after edge m therefore uses the set that was active just before edge m-1-k. Outputs after edge L+10 and later use only the new set.
- R6: `out_valid` first rises after edge 11 following reset release, provided no load has occurred.
- R7: After a load at edge L, `out_valid` is 0 after edges L through L+9 and is 1 again after edge L+10. A further load in that window restarts the wait.
- R8: Once high, `out_valid` stays high until the next load or reset.
- R9: Each tap stage holds a sum word and a carry word. Modulo 2^22, their total equals the tap's product plus the incoming pair from the previous edge.
- R10: Samples and coefficients are two's complement, 8 and 10 bits wide. The 22-bit internal total cannot overflow. At the extremes (x = -128 with all taps -512 or all taps 511), the output equals the exact floored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | 8 | Signed input sample, one per clock |
| coef_in | input | 90 | Nine packed signed 10-bit coefficients, tap k at bits k*10 upward |
| coef_load | input | 1 | One-cycle strobe that captures `coef_in` into all taps |
| y_out | output | 12 | Filtered output, full sum shifted right by 10 |
| out_valid | output | 1 | Output reflects real samples and the current coefficient set only |

## Verification
The stage assertions take for granted that `x_in` and the coefficient registers carry known two's complement values on every edge after reset, so that the compressor's modular total can be compared with the one-edge-earlier product. The sequencer assertions assume that a load strobe is sampled only on a clock edge, so that one high sample means exactly one load. The bench drives every input at the falling edge with fully known values from a deterministic generator. It holds the strobe for whole cycles, including back-to-back loads. It checks every output word and every valid flag against a model that records, edge by edge, the captured sample and the active coefficient set.

// File: rtl/cs_fir_pkg.sv
package cs_fir_pkg;

    localparam int TAPS_DEF = 9;
    localparam int XW_DEF   = 8;
    localparam int CW_DEF   = 10;
    localparam int OW_DEF   = 12;

    typedef enum logic [1:0] {
        ST_PRIME  = 2'd0,
        ST_RUN    = 2'd1,
        ST_SETTLE = 2'd2
    } vstate_t;

endpackage

// File: rtl/cs_coef_bank.sv
module cs_coef_bank #(
    parameter int TAPS = 9,
    parameter int CW   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TAPS*CW-1:0]   coef_in,
    input  logic                 load,
    output logic [TAPS*CW-1:0]   coef_q
);

    // whole set captured on one edge so every tap switches together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_q <= '0;
        end else if (load) begin
            coef_q <= coef_in;
        end
    end

    // R4
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(coef_q));

endmodule

// File: rtl/cs_tap_cell.sv
module cs_tap_cell #(
    parameter int XW = 8,
    parameter int CW = 10,
    parameter int AW = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [CW-1:0] c_i,
    input  logic [AW-1:0]        s_i,
    input  logic [AW-1:0]        k_i,
    output logic [AW-1:0]        s_o,
    output logic [AW-1:0]        k_o
);

    localparam int PW = XW + CW;

    logic signed [PW-1:0] prod;
    logic [AW-1:0]        p;
    logic [AW-1:0]        s_d;
    logic [AW-1:0]        maj;
    logic [AW-1:0]        s_q;
    logic [AW-1:0]        k_q;

    // signed product, sign extended into the accumulator width
    assign prod = PW'(x_i) * PW'(c_i);
    assign p    = AW'(prod);

    // 3:2 compression: no carry propagation inside the stage
    assign s_d = p ^ s_i ^ k_i;
    assign maj = (p & s_i) | (p & k_i) | (s_i & k_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            k_q <= '0;
        end else begin
            s_q <= s_d;
            k_q <= maj << 1;
        end
    end

    assign s_o = s_q;
    assign k_o = k_q;

    // R9
    csa_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (AW'(s_q + k_q) == $past(AW'(p + s_i + k_i))));

endmodule

// File: rtl/cs_valid_ctrl.sv
module cs_valid_ctrl import cs_fir_pkg::*; #(
    parameter int FILL     = 11,
    parameter int SETTLE_N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic valid
);

    localparam int CMAX = (FILL > SETTLE_N) ? FILL : SETTLE_N;
    localparam int CNTW = (CMAX > 1) ? $clog2(CMAX) : 1;

    vstate_t         state_q, state_d;
    logic [CNTW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_PRIME: begin
                if (load) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNTW'(FILL - 1)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (load) begin
                    cnt_d = '0;
                end else if (cnt_q == CNTW'(SETTLE_N - 1)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (load) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_PRIME;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        valid = (state_q == ST_RUN);
    end

    // R7
    load_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !valid);

    // R7
    settle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SETTLE) && !load |=> (state_q != ST_SETTLE));

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !load |=> valid);

endmodule

// File: rtl/cs_fir9.sv
module cs_fir9 import cs_fir_pkg::*; #(
    parameter int TAPS = TAPS_DEF,
    parameter int XW   = XW_DEF,
    parameter int CW   = CW_DEF,
    parameter int OW   = OW_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [XW-1:0] x_in,
    input  logic [TAPS*CW-1:0]   coef_in,
    input  logic                 coef_load,
    output logic [OW-1:0]        y_out,
    output logic                 out_valid
);

    localparam int AW       = XW + CW + $clog2(TAPS);
    localparam int SH       = AW - OW;
    localparam int PIPE     = 2;
    localparam int FILL     = TAPS + PIPE;
    localparam int SETTLE_N = TAPS + 1;

    logic signed [XW-1:0] x_q;
    logic [TAPS*CW-1:0]   coef_q;
    logic [AW-1:0]        s_ch [0:TAPS];
    logic [AW-1:0]        k_ch [0:TAPS];
    logic [AW-1:0]        full;
    logic [OW-1:0]        y_q;

    // input sample register, broadcast to every tap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_in;
        end
    end

    cs_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .coef_in (coef_in),
        .load    (coef_load),
        .coef_q  (coef_q)
    );

    // oldest tap starts from an empty pair
    assign s_ch[TAPS] = '0;
    assign k_ch[TAPS] = '0;

    generate
        for (genvar g = 0; g < TAPS; g++) begin : g_tap
            cs_tap_cell #(.XW(XW), .CW(CW), .AW(AW)) u_tap (
                .clk   (clk),
                .rst_n (rst_n),
                .x_i   (x_q),
                .c_i   (coef_q[g*CW +: CW]),
                .s_i   (s_ch[g+1]),
                .k_i   (k_ch[g+1]),
                .s_o   (s_ch[g]),
                .k_o   (k_ch[g])
            );
        end
    endgenerate

    // single carry-propagate merge, then keep the top bits
    assign full = s_ch[0] + k_ch[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q <= '0;
        end else begin
            y_q <= OW'(full >> SH);
        end
    end

    assign y_out = y_q;

    cs_valid_ctrl #(.FILL(FILL), .SETTLE_N(SETTLE_N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (coef_load),
        .valid (out_valid)
    );

endmodule

// File: tb/cs_fir9_tb.sv
module cs_fir9_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS = 9;
    localparam int CW   = 10;
    localparam int SH   = 10;
    localparam int HN   = 4096;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [7:0]    x_in = '0;
    logic [TAPS*CW-1:0]   coef_in = '0;
    logic                 coef_load = 1'b0;
    logic [11:0]          y_out;
    logic                 out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int edge_n = 0;
    int base   = 0;
    int last_load = -100;
    int xh [0:HN-1];
    int ch [0:HN-1][0:TAPS-1];
    int ma [0:TAPS-1];
    bit [31:0] seed = 32'h1234_5679;

    cs_fir9 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .x_in      (x_in),
        .coef_in   (coef_in),
        .coef_load (coef_load),
        .y_out     (y_out),
        .out_valid (out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // per-edge record of captured sample and active coefficient set
    always @(posedge clk) begin
        if (!rst_n) begin
            base = edge_n;
            last_load = -100;
            for (int k = 0; k < TAPS; k++) ma[k] = 0;
        end else begin
            edge_n = edge_n + 1;
            xh[edge_n] = int'(x_in);
            for (int k = 0; k < TAPS; k++) ch[edge_n][k] = ma[k];
            if (coef_load) begin
                for (int k = 0; k < TAPS; k++) ma[k] = int'($signed(coef_in[k*CW +: CW]));
                last_load = edge_n;
            end
        end
    end

    function automatic int exp_y(int m);
        longint acc = 0;
        for (int k = 0; k < TAPS; k++) begin
            int ec = m - 1 - k;
            int ex = m - 2 - k;
            if (ex > base) acc += longint'(ch[ec][k]) * longint'(xh[ex]);
        end
        return int'(acc >>> SH);
    endfunction

    function automatic int exp_v(int m);
        return ((m - base >= 11) && (m >= last_load + 10)) ? 1 : 0;
    endfunction

    function automatic bit [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic chk(string tag, int got, int expv);
        n_chk++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s edge=%0d got=%0d exp=%0d", tag, edge_n, got, expv);
        end
    endtask

    // one clock: drive at falling edge, check after the next falling edge
    task automatic cyc(int xv, bit ld, string tag);
        x_in = xv[7:0];
        coef_load = ld;
        @(posedge clk);
        @(negedge clk);
        coef_load = 1'b0;
        chk(tag, int'($signed(y_out)), exp_y(edge_n));
        chk("R6 R7 R8 valid", int'(out_valid), exp_v(edge_n));
    endtask

    task automatic set_coefs(int c0, int c1, int c2, int c3, int c4,
                             int c5, int c6, int c7, int c8);
        int cf [0:TAPS-1];
        cf = '{c0, c1, c2, c3, c4, c5, c6, c7, c8};
        for (int k = 0; k < TAPS; k++) coef_in[k*CW +: CW] = cf[k][CW-1:0];
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset y", int'($signed(y_out)), 0);
            chk("R1 reset valid", int'(out_valid), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_zero_coef();
        // R1: no load yet, coefficients must read as zero
        for (int i = 0; i < 14; i++) begin
            cyc(int'($signed(rnd() & 32'hff)), 1'b0, "R1 zero coef");
            chk("R1 zero output", int'($signed(y_out)), 0);
        end
    endtask

    task automatic t_impulse();
        // R3: tap order visible as a scaled coefficient sequence
        set_coefs(511, -400, 300, -200, 100, -50, 250, -350, 450);
        cyc(0, 1'b1, "R2 R3 load");
        cyc(127, 1'b0, "R2 R3 impulse");
        for (int i = 0; i < 16; i++) cyc(0, 1'b0, "R2 R3 impulse tail");
        cyc(-128, 1'b0, "R2 R3 neg impulse");
        for (int i = 0; i < 12; i++) cyc(0, 1'b0, "R2 R3 neg tail");
    endtask

    task automatic t_hold();
        // R4: coef_in wiggles without strobe, output must follow old set
        for (int i = 0; i < 20; i++) begin
            coef_in = {rnd(), rnd(), rnd()};
            cyc(int'($signed(rnd() & 32'hff)), 1'b0, "R4 no strobe");
        end
    endtask

    task automatic t_extremes();
        set_coefs(-512, -512, -512, -512, -512, -512, -512, -512, -512);
        cyc(-128, 1'b1, "R10 load min");
        for (int i = 0; i < 14; i++) cyc(-128, 1'b0, "R10 min coef");
        chk("R10 extreme positive", int'($signed(y_out)), 576);
        set_coefs(511, 511, 511, 511, 511, 511, 511, 511, 511);
        cyc(-128, 1'b1, "R10 load max");
        for (int i = 0; i < 14; i++) cyc(-128, 1'b0, "R10 max coef");
        chk("R10 extreme negative", int'($signed(y_out)), -575);
    endtask

    task automatic t_switch();
        // R5: mixed-set transient after a reload mid-stream
        set_coefs(37, -81, 120, -7, 255, -300, 64, 9, -140);
        cyc(int'($signed(rnd() & 32'hff)), 1'b1, "R5 first set");
        for (int i = 0; i < 15; i++) cyc(int'($signed(rnd() & 32'hff)), 1'b0, "R5 stream");
        set_coefs(-200, 180, -90, 400, -33, 17, -500, 222, 5);
        cyc(int'($signed(rnd() & 32'hff)), 1'b1, "R5 second set");
        for (int i = 0; i < 15; i++) cyc(int'($signed(rnd() & 32'hff)), 1'b0, "R5 transition");
    endtask

    task automatic t_back_to_back();
        // R7: consecutive strobes restart the settle wait
        for (int i = 0; i < 3; i++) begin
            coef_in = {rnd(), rnd(), rnd()};
            cyc(int'($signed(rnd() & 32'hff)), 1'b1, "R7 repeated load");
        end
        for (int i = 0; i < 14; i++) cyc(int'($signed(rnd() & 32'hff)), 1'b0, "R7 settle");
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            bit ld = (i % 37 == 5);
            if (ld) coef_in = {rnd(), rnd(), rnd()};
            cyc(int'($signed(rnd() & 32'hff)), ld, "R2 random");
        end
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid reset y", int'($signed(y_out)), 0);
        chk("R1 mid reset valid", int'(out_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 14; i++) cyc(int'($signed(rnd() & 32'hff)), 1'b0, "R1 after reset");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_zero_coef();
        t_impulse();
        t_hold();
        t_extremes();
        t_switch();
        t_back_to_back();
        t_random();
        t_mid_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule